// File: doc/BRIEF.md
# Operand-Sized Shift and Rotate Execution Unit

This unit performs the shift and rotate operations of an integer datapath on a 64-bit register. It takes a source value, a shift count, an operand size of 1, 2, 4 or 8 bytes, the incoming carry flag and the current destination value. It produces the new destination value and a carry-out bit.

Seven operations are supported. There are three shifts: logical left, logical right and arithmetic right. There are two plain rotates, right and left. There are two rotates that pass through the carry flag, right and left. The count comes either from a register or from an immediate field, and it is masked to a width set by the operand size. The result is written only into the low bytes that the operand size selects. The other bytes of the destination keep their old values.

Results are registered. An operation accepted with `in_valid` shows on `result`, `carry_out` and `out_valid` one clock later. While no operation is accepted, the output registers hold their values.

Top module: `shrot_unit`

## Requirements
- R1: The effective count is the selected count masked to 6 bits when `size` is 3 (8 bytes), and masked to 5 bits when `size` is 0, 1 or 2 (1, 2 or 4 bytes). The operand width W is 8, 16, 32 or 64 bits for `size` 0, 1, 2 or 3.
- R2: When `use_imm` is 1 the count comes from `cnt_imm`, and `cnt_reg` has no effect. When `use_imm` is 0 the count comes from `cnt_reg`.
- R3: Op code 0 (left shift) moves the operand left by n and fills with zeros. An effective count at or above W gives zero. The carry-out is the last bit shifted past bit W-1, and it is 0 when n > W.
- R4: Op code 1 (logical right shift) fills the vacated upper bits inside W with zeros. The carry-out is the last bit shifted out of bit 0.
- R5: Op code 2 (arithmetic right shift) fills the vacated bits with bit W-1 of the source. When n >= W every bit of the field equals that sign bit. The carry-out is the last bit shifted out.
- R6: Op codes 3 and 4 rotate the W-bit field right and left by n modulo W. For the right rotate the carry-out is the new bit W-1. For the left rotate the carry-out is the new bit 0.
- R7: Op code 5 rotates right through carry over W+1 bits, by k = n modulo (W+1). The old carry lands at bit W-k. Source bits wrap in above it only when k exceeds 1. The carry-out is source bit k-1.
- R8: Op code 6 rotates left through carry by k = n modulo (W+1). The old carry lands at bit k-1. High source bits fill below it only when k exceeds 1. The carry-out is source bit W-k.
- R9: For op codes 3 to 6 with an effective count of zero, the result equals `old_dest` unchanged. Op code 7 always returns `old_dest` and `carry_in`.
- R10: For non-pass operations, result bits at and above W equal the same bits of `old_dest`.
- R11: With an effective count of zero, `carry_out` equals `carry_in` for every op code.
- R12: An operation presented with `in_valid` appears on `result` and `carry_out` one cycle later, and `out_valid` follows `in_valid` with one cycle of delay. While `in_valid` is 0, `result` and `carry_out` hold.
- R13: During reset, `out_valid`, `result` and `carry_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 3 | Operation code (0 shl, 1 shr, 2 sar, 3 ror, 4 rol, 5 rcr, 6 rcl, 7 pass) |
| size | input | 2 | Operand size code: 0/1/2/3 = 1/2/4/8 bytes |
| src | input | 64 | Source value |
| old_dest | input | 64 | Current destination value |
| use_imm | input | 1 | Select the immediate count |
| cnt_reg | input | 6 | Low count bits from the register operand |
| cnt_imm | input | 6 | Low count bits from the immediate field |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 64 | Merged destination value |
| carry_out | output | 1 | Carry flag after the operation |

## Verification
The clocked properties compare each output with the inputs from the previous cycle. They therefore assume that `in_valid` is held low for the whole of reset, so that the first cycle after release never refers to an operation captured during reset. The bench drives every input on the falling edge and keeps `in_valid` at 0 until after `rst_n` rises. The bench also feeds effective counts that cover zero, one, exactly W, above W, and a full W+1 cycle through carry, so that every branch the properties guard is reached.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_RCR  = 3'd5,
    OP_RCL  = 3'd6,
    OP_PASS = 3'd7
  } sr_op_e;

  function automatic logic op_is_rotate(sr_op_e o);
    return (o == OP_ROR) || (o == OP_ROL) || (o == OP_RCR) || (o == OP_RCL);
  endfunction
endpackage

// File: rtl/shrot_cnt.sv
// Count selection, size masking, operand width/mask and carry-rotate modulus.
module shrot_cnt #(
  parameter int DATA_W = 64
) (
  input  logic                            use_imm,
  input  logic [$clog2(DATA_W)-1:0]       cnt_reg,
  input  logic [$clog2(DATA_W)-1:0]       cnt_imm,
  input  logic [1:0]                      size,
  output logic [$clog2(DATA_W)-1:0]       amt,
  output logic [$clog2(DATA_W):0]         amt_rc,
  output logic [$clog2(DATA_W):0]         width,
  output logic [DATA_W-1:0]               wmask
);
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int RC_STEPS = ((1 << (CNT_W - 1)) - 1) / 9;

  logic [CNT_W-1:0] raw;
  logic [CNT_W:0]   w_tab [4];
  logic [DATA_W-1:0] m_tab [4];
  logic [CNT_W:0]   modv;
  logic [CNT_W:0]   k;

  assign raw = use_imm ? cnt_imm : cnt_reg;
  assign amt = (size == 2'd3) ? raw : {1'b0, raw[CNT_W-2:0]};

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int BITS = 8 << s;
    assign w_tab[s] = (CNT_W+1)'(BITS);
    if (BITS >= DATA_W) begin : g_full
      assign m_tab[s] = '1;
    end else begin : g_part
      assign m_tab[s] = {{(DATA_W-BITS){1'b0}}, {BITS{1'b1}}};
    end
  end

  assign width = w_tab[size];
  assign wmask = m_tab[size];
  assign modv  = width + 1'b1;

  // Reduce the count modulo W+1 for rotates through carry.
  always_comb begin
    k = {1'b0, amt};
    for (int i = 0; i < RC_STEPS; i++) begin
      if (k >= modv) k = k - modv;
    end
  end
  assign amt_rc = k;
endmodule

// File: rtl/shrot_lin.sv
// Logical and arithmetic shifts on the size-masked operand.
module shrot_lin
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  sr_op_e                    op,
  input  logic [DATA_W-1:0]         src,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic [$clog2(DATA_W):0]   width,
  input  logic [DATA_W-1:0]         wmask,
  output logic [DATA_W-1:0]         res,
  output logic                      cout
);
  logic [DATA_W-1:0] srcm;
  logic [DATA_W-1:0] sext;
  logic              sign;

  assign srcm = src & wmask;
  assign sign = srcm[width - 1'b1];
  assign sext = sign ? (srcm | ~wmask) : srcm;

  always_comb begin
    res  = '0;
    cout = 1'b0;
    case (op)
      OP_SHL: begin
        res  = srcm << amt;
        cout = (amt != '0) && ({1'b0, amt} <= width) ? srcm[width - {1'b0, amt}] : 1'b0;
      end
      OP_SHR: begin
        res  = srcm >> amt;
        cout = srcm[amt - 1'b1];
      end
      OP_SAR: begin
        res  = $signed(sext) >>> amt;
        cout = sext[amt - 1'b1];
      end
      default: begin
        res  = '0;
        cout = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/shrot_rot.sv
// Plain rotates and rotates through carry.
module shrot_rot
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  sr_op_e                    op,
  input  logic [1:0]                size,
  input  logic [DATA_W-1:0]         src,
  input  logic                      cin,
  input  logic [$clog2(DATA_W)-1:0] amt,
  input  logic [$clog2(DATA_W):0]   amt_rc,
  input  logic [$clog2(DATA_W):0]   width,
  input  logic [DATA_W-1:0]         wmask,
  output logic [DATA_W-1:0]         res,
  output logic                      cout
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] rep_tab [4];
  logic [DATA_W-1:0] rep;
  logic [DATA_W-1:0] srcm;
  logic [DATA_W-1:0] cinx;
  logic [CNT_W:0]    dw_amt;
  logic [DATA_W-1:0] rr, rl, cr, cl;

  // Periodic copy of the operand: a 64-bit rotate of it is a W-bit rotate.
  for (genvar s = 0; s < 4; s++) begin : g_rep
    localparam int BITS = 8 << s;
    assign rep_tab[s] = {(DATA_W/BITS){src[BITS-1:0]}};
  end

  assign rep    = rep_tab[size];
  assign srcm   = src & wmask;
  assign cinx   = {{(DATA_W-1){1'b0}}, cin};
  assign dw_amt = (CNT_W+1)'(DATA_W) - {1'b0, amt};

  assign rr = (rep >> amt) | (rep << dw_amt);
  assign rl = (rep << amt) | (rep >> dw_amt);
  assign cr = (srcm >> amt_rc) | (cinx << (width - amt_rc))
            | (srcm << (width - amt_rc + 1'b1));
  assign cl = (srcm << amt_rc) | (cinx << (amt_rc - 1'b1))
            | (srcm >> (width - amt_rc + 1'b1));

  always_comb begin
    res  = '0;
    cout = cin;
    case (op)
      OP_ROR: begin
        res  = rr & wmask;
        cout = rr[width - 1'b1];
      end
      OP_ROL: begin
        res  = rl & wmask;
        cout = rl[0];
      end
      OP_RCR: begin
        res  = (amt_rc == '0) ? srcm : (cr & wmask);
        cout = (amt_rc == '0) ? cin : srcm[amt_rc - 1'b1];
      end
      OP_RCL: begin
        res  = (amt_rc == '0) ? srcm : (cl & wmask);
        cout = (amt_rc == '0) ? cin : srcm[width - amt_rc];
      end
      default: begin
        res  = '0;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] old_dest,
  input  logic              use_imm,
  input  logic [CNT_W-1:0]  cnt_reg,
  input  logic [CNT_W-1:0]  cnt_imm,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  sr_op_e            op_e;
  logic [CNT_W-1:0]  amt;
  logic [CNT_W:0]    amt_rc;
  logic [CNT_W:0]    width;
  logic [DATA_W-1:0] wmask;
  logic [DATA_W-1:0] lin_res, rot_res, core_res;
  logic              lin_c, rot_c, core_c;
  logic [DATA_W-1:0] res_d;
  logic              c_d;
  logic              vld_q;
  logic [DATA_W-1:0] res_q;
  logic              c_q;

  assign op_e = sr_op_e'(op);

  shrot_cnt #(.DATA_W(DATA_W)) u_cnt (
    .use_imm (use_imm),
    .cnt_reg (cnt_reg),
    .cnt_imm (cnt_imm),
    .size    (size),
    .amt     (amt),
    .amt_rc  (amt_rc),
    .width   (width),
    .wmask   (wmask)
  );

  shrot_lin #(.DATA_W(DATA_W)) u_lin (
    .op    (op_e),
    .src   (src),
    .amt   (amt),
    .width (width),
    .wmask (wmask),
    .res   (lin_res),
    .cout  (lin_c)
  );

  shrot_rot #(.DATA_W(DATA_W)) u_rot (
    .op     (op_e),
    .size   (size),
    .src    (src),
    .cin    (carry_in),
    .amt    (amt),
    .amt_rc (amt_rc),
    .width  (width),
    .wmask  (wmask),
    .res    (rot_res),
    .cout   (rot_c)
  );

  assign core_res = op_is_rotate(op_e) ? rot_res : lin_res;
  assign core_c   = op_is_rotate(op_e) ? rot_c   : lin_c;

  // Next-state: merge into the low bytes, or keep the destination.
  always_comb begin
    if ((op_e == OP_PASS) || (op_is_rotate(op_e) && (amt == '0))) begin
      res_d = old_dest;
      c_d   = carry_in;
    end else begin
      res_d = (old_dest & ~wmask) | (core_res & wmask);
      c_d   = (amt == '0) ? carry_in : core_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      c_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        c_q   <= c_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign carry_out = c_q;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] old_dest,
  input logic              use_imm,
  input logic [CNT_W-1:0]  cnt_reg,
  input logic [CNT_W-1:0]  cnt_imm,
  input logic              carry_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              carry_out
);
  logic [CNT_W-1:0] sel_cnt;
  logic             cnt_zero;
  logic             rot_op;

  assign sel_cnt  = use_imm ? cnt_imm : cnt_reg;
  assign cnt_zero = (size == 2'd3) ? (sel_cnt == '0) : (sel_cnt[CNT_W-2:0] == '0);
  assign rot_op   = (op >= 3'd3) && (op <= 3'd6);

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out)));
  p_rot_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rot_op && cnt_zero) |=> (result == $past(old_dest)));
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 3'd7)) |=> (result == $past(old_dest)));
  p_carry_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_zero) |=> (carry_out == $past(carry_in)));
  p_upper_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (size == 2'd0)) |=> (result[DATA_W-1:8] == $past(old_dest[DATA_W-1:8])));
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W)) u_shrot_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .size      (size),
  .old_dest  (old_dest),
  .use_imm   (use_imm),
  .cnt_reg   (cnt_reg),
  .cnt_imm   (cnt_imm),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [63:0] src, old_dest;
  logic        use_imm;
  logic [5:0]  cnt_reg, cnt_imm;
  logic        carry_in;
  logic        out_valid;
  logic [63:0] result;
  logic        carry_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  shrot_unit i_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .src(src), .old_dest(old_dest), .use_imm(use_imm), .cnt_reg(cnt_reg),
    .cnt_imm(cnt_imm), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .carry_out(carry_out)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-serial reference: one single-bit step per count.
  function automatic logic [64:0] model(logic [2:0] o, logic [1:0] sz,
      logic [63:0] s, logic [63:0] od, logic [5:0] c6, logic ci);
    int w = 8 << sz;
    int n = (sz == 2'd3) ? int'(c6) : int'(c6[4:0]);
    logic [63:0] wm = (sz == 2'd3) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] r = s & wm;
    logic c = ci;
    logic b;
    if (o == 3'd7 || (o >= 3'd3 && n == 0)) return {ci, od};
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd0: begin c = r[w-1]; r = (r << 1) & wm; end
        3'd1: begin c = r[0]; r = r >> 1; end
        3'd2: begin b = r[w-1]; c = r[0]; r = (r >> 1) | ({63'd0, b} << (w-1)); end
        3'd3: begin c = r[0]; r = (r >> 1) | ({63'd0, c} << (w-1)); end
        3'd4: begin c = r[w-1]; r = ((r << 1) & wm) | {63'd0, c}; end
        3'd5: begin b = r[0]; r = (r >> 1) | ({63'd0, c} << (w-1)); c = b; end
        default: begin b = r[w-1]; r = ((r << 1) & wm) | {63'd0, c}; c = b; end
      endcase
    end
    return {c, (od & ~wm) | r};
  endfunction

  task automatic run_op(string tag, logic [2:0] o, logic [1:0] sz, logic [63:0] s,
      logic [63:0] od, logic ui, logic [5:0] cr, logic [5:0] ci6, logic ci);
    logic [64:0] e = model(o, sz, s, od, ui ? ci6 : cr, ci);
    @(negedge clk);
    in_valid = 1'b1; op = o; size = sz; src = s; old_dest = od;
    use_imm = ui; cnt_reg = cr; cnt_imm = ci6; carry_in = ci;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R12 valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " result"}, result, e[63:0]);
    chk({tag, " carry"}, {63'd0, carry_out}, {63'd0, e[64]});
  endtask

  task automatic t_reset();
    chk("R13 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R13 reset result", result, 64'd0);
    chk("R13 reset carry", {63'd0, carry_out}, 64'd0);
  endtask

  task automatic t_shl();
    run_op("R3 shl8 n1", 3'd0, 2'd3, 64'h8000_0000_0000_0001, 64'h0, 0, 6'd1, 6'd0, 0);
    chk("R3 shl8 n1 literal", result, 64'h2);
    run_op("R3 shl1 n8", 3'd0, 2'd0, 64'h81, 64'h0, 0, 6'd8, 6'd0, 0);
    run_op("R3 shl1 n9", 3'd0, 2'd0, 64'hFF, 64'h0, 0, 6'd9, 6'd0, 1);
    run_op("R3 shl2 n5", 3'd0, 2'd1, 64'hF00F, 64'h0, 0, 6'd5, 6'd0, 0);
  endtask

  task automatic t_shr();
    run_op("R4 shr4 n4", 3'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 6'd4, 6'd0, 0);
    chk("R4 shr4 literal", result, 64'h0FFF_FFFF);
    run_op("R4 shr2 n20", 3'd1, 2'd1, 64'hFFFF, 64'h0, 0, 6'd20, 6'd0, 1);
    run_op("R4 shr8 n63", 3'd1, 2'd3, 64'h8000_0000_0000_0000, 64'h0, 0, 6'd63, 6'd0, 0);
  endtask

  task automatic t_sar();
    run_op("R5 sar2 n3", 3'd2, 2'd1, 64'h8001, 64'h0, 0, 6'd3, 6'd0, 0);
    chk("R5 sar2 literal", result, 64'hF000);
    run_op("R5 sar1 n12", 3'd2, 2'd0, 64'h80, 64'h0, 0, 6'd12, 6'd0, 0);
    run_op("R5 sar8 n63", 3'd2, 2'd3, 64'h8123_4567_89AB_CDEF, 64'h0, 0, 6'd63, 6'd0, 0);
    run_op("R5 sar4 pos", 3'd2, 2'd2, 64'h7000_0001, 64'h0, 0, 6'd2, 6'd0, 1);
  endtask

  task automatic t_rot();
    run_op("R6 ror1 n1", 3'd3, 2'd0, 64'h81, 64'h0, 0, 6'd1, 6'd0, 0);
    chk("R6 ror1 literal", result, 64'hC0);
    run_op("R6 ror1 n8", 3'd3, 2'd0, 64'h96, 64'h0, 0, 6'd8, 6'd0, 0);
    run_op("R6 rol4 n8", 3'd4, 2'd2, 64'h1234_5678, 64'h0, 0, 6'd8, 6'd0, 0);
    run_op("R6 rol2 n17", 3'd4, 2'd1, 64'h8421, 64'h0, 0, 6'd17, 6'd0, 0);
    run_op("R6 ror8 n13", 3'd3, 2'd3, 64'hDEAD_BEEF_0123_4567, 64'h0, 0, 6'd13, 6'd0, 1);
  endtask

  task automatic t_rcr();
    run_op("R7 rcr1 n1", 3'd5, 2'd0, 64'h02, 64'h0, 0, 6'd1, 6'd0, 1);
    chk("R7 rcr1 literal", result, 64'h81);
    run_op("R7 rcr1 n8", 3'd5, 2'd0, 64'hA5, 64'h0, 0, 6'd8, 6'd0, 1);
    run_op("R7 rcr1 n9", 3'd5, 2'd0, 64'hA5, 64'h0, 0, 6'd9, 6'd0, 1);
    run_op("R7 rcr1 n31", 3'd5, 2'd0, 64'h3C, 64'h0, 0, 6'd31, 6'd0, 0);
    run_op("R7 rcr8 n63", 3'd5, 2'd3, 64'hF0F0_1234_8765_0001, 64'h0, 0, 6'd63, 6'd0, 1);
  endtask

  task automatic t_rcl();
    run_op("R8 rcl1 n1", 3'd6, 2'd0, 64'h80, 64'h0, 0, 6'd1, 6'd0, 1);
    chk("R8 rcl1 literal", result, 64'h01);
    run_op("R8 rcl2 n16", 3'd6, 2'd1, 64'h8001, 64'h0, 0, 6'd16, 6'd0, 0);
    run_op("R8 rcl4 n31", 3'd6, 2'd2, 64'hC000_0003, 64'h0, 0, 6'd31, 6'd0, 1);
    run_op("R8 rcl8 n64m", 3'd6, 2'd3, 64'h8000_0000_0000_0001, 64'h0, 0, 6'd5, 6'd0, 0);
  endtask

  task automatic t_zero();
    for (int o = 3; o <= 6; o++) begin
      run_op("R9 rot zero", 3'(o), 2'd2, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD,
             0, 6'd0, 6'd0, 1);
    end
    run_op("R11 shl zero", 3'd0, 2'd1, 64'hBEEF, 64'h5555_5555_5555_5555, 0, 6'd0, 6'd0, 1);
    chk("R11 shl zero carry literal", {63'd0, carry_out}, 64'd1);
    run_op("R9 pass", 3'd7, 2'd0, 64'hFF, 64'h0123_4567_89AB_CDEF, 0, 6'd3, 6'd0, 1);
    chk("R9 pass literal", result, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_merge();
    run_op("R10 merge1", 3'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0123_4567_89AB_CDEF, 0, 6'd2, 6'd0, 0);
    chk("R10 merge1 literal", result, 64'h0123_4567_89AB_CD3C);
    run_op("R10 merge2", 3'd4, 2'd1, 64'h1234, 64'hFFFF_FFFF_FFFF_FFFF, 0, 6'd4, 6'd0, 0);
    run_op("R10 merge4", 3'd2, 2'd2, 64'h8000_0000, 64'h7777_7777_0000_0000, 0, 6'd1, 6'd0, 0);
  endtask

  task automatic t_mask();
    run_op("R1 mask2 0x23", 3'd0, 2'd1, 64'h0001, 64'h0, 0, 6'h23, 6'd0, 0);
    chk("R1 mask2 literal", result, 64'h0008);
    run_op("R1 mask8 0x23", 3'd0, 2'd3, 64'h0001, 64'h0, 0, 6'h23, 6'd0, 0);
    chk("R1 mask8 literal", result, 64'h8_0000_0000);
    run_op("R1 mask4 0x20", 3'd3, 2'd2, 64'h1234_5678, 64'h9999_9999_9999_9999, 0, 6'h20, 6'd0, 0);
  endtask

  task automatic t_imm();
    run_op("R2 imm", 3'd1, 2'd3, 64'hF000_0000_0000_0000, 64'h0, 1, 6'd1, 6'd8, 0);
    chk("R2 imm literal", result, 64'h00F0_0000_0000_0000);
    run_op("R2 reg", 3'd1, 2'd3, 64'hF000_0000_0000_0000, 64'h0, 0, 6'd1, 6'd8, 0);
  endtask

  task automatic t_hold();
    logic [63:0] r0 = result;
    logic        c0 = carry_out;
    @(negedge clk);
    in_valid = 1'b0; op = 3'd0; src = 64'hFFFF; cnt_reg = 6'd1; carry_in = ~c0;
    old_dest = ~r0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 hold valid", {63'd0, out_valid}, 64'd0);
    chk("R12 hold result", result, r0);
    chk("R12 hold carry", {63'd0, carry_out}, {63'd0, c0});
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; size = '0; src = '0; old_dest = '0;
    use_imm = 1'b0; cnt_reg = '0; cnt_imm = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_shl();
    t_shr();
    t_sar();
    t_rot();
    t_rcr();
    t_rcl();
    t_zero();
    t_merge();
    t_mask();
    t_imm();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule